// File: doc/BRIEF.md
# Priority Bus Arbitration Controller

This controller decides which of two agents owns a shared system bus. One side is a symmetric agent, normally the processor, which asks for the bus by pulling its active-low request line low. The other side is a high-priority agent, normally the chipset, whose own active-low priority request overrides the symmetric agent. The one exception is a locked sequence that is already under way. A locked sequence may finish before ownership moves.

The controller counts the transactions that the priority agent has issued and not yet completed. It keeps the priority agent as owner until that count is zero, even if the priority request is withdrawn early. When nobody is requesting, the bus stays parked with whichever agent owned it last. Every input is sampled on the rising clock edge. Each output is decoded from the registered state or from the registered count, so any response appears in the cycle after the edge that sampled its cause.

The state machine has six states:
- `ARB_IDLE`: no owner. This is the state after reset.
- `ARB_SA_OWN`: the symmetric agent owns the bus and may issue.
- `ARB_SA_LOCK`: the symmetric agent finishes a locked sequence while a priority request waits.
- `ARB_SA_PARK`: the bus is parked with the symmetric agent.
- `ARB_PA_OWN`: the priority agent owns the bus.
- `ARB_PA_PARK`: the bus is parked with the priority agent.

The transitions are as follows:
- A priority request seen in `ARB_IDLE`, `ARB_SA_OWN`, `ARB_SA_PARK` or `ARB_PA_PARK` moves to `ARB_PA_OWN`. The exception is a symmetric-side state with the lock flag set, which moves to `ARB_SA_LOCK` instead.
- `ARB_SA_LOCK` stays put while the lock flag stays high. When the lock flag drops, it goes to `ARB_PA_OWN` if the priority request is still active. Otherwise it goes to `ARB_SA_OWN` or `ARB_SA_PARK`, depending on the symmetric request.
- A symmetric request with no priority request moves `ARB_IDLE`, `ARB_SA_PARK` or `ARB_PA_PARK` to `ARB_SA_OWN`.
- `ARB_SA_OWN` drops to `ARB_SA_PARK` when its request goes away.
- `ARB_PA_OWN` leaves only when three things hold together: the priority request is inactive, the pending count is zero, and no issue pulse is present. It then goes to `ARB_SA_OWN` if the symmetric agent is requesting, and to `ARB_PA_PARK` if not.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released with both requests inactive, the outputs are: `sa_grant`=0, `pa_grant`=0, `sa_issue_ok`=0, `pa_pending`=0 and `pa_drop_ok`=1.
- R2: A symmetric request (`sa_req_n`=0) with the priority request inactive (`pa_req_n`=1), sampled while the bus is unowned or parked, gives `sa_grant`=1 and `sa_issue_ok`=1 in the next cycle.
- R3: An active priority request (`pa_req_n`=0) with `sa_lock`=0 gives `pa_grant`=1 and `sa_issue_ok`=0 in the next cycle. The priority agent wins when both agents request from the unowned state.
- R4: A priority request sampled while the symmetric agent is in control with `sa_lock`=1 is deferred. `sa_grant` and `sa_issue_ok` stay 1 for as long as `sa_lock` stays 1. The cycle after `sa_lock` is sampled 0 with the priority request still active, the priority agent owns the bus.
- R5: `pa_pending` is a binary count. It rises by one on a cycle with `pa_issue`=1 and `pa_done`=0. It falls by one on a cycle with `pa_done`=1 and `pa_issue`=0. It holds when both are 1 or both are 0.
- R6: `pa_drop_ok` is 1 exactly when `pa_pending` is zero.
- R7: While the priority agent owns the bus and `pa_pending` is nonzero, deasserting `pa_req_n` has no effect: `pa_grant` stays 1 and `sa_issue_ok` stays 0.
- R8: When the priority agent owns the bus with zero pending, no issue pulse and `pa_req_n`=1, a requesting symmetric agent has `sa_grant`=1 and `sa_issue_ok`=1 one cycle later.
- R9: When neither agent requests, ownership stays with the last owner: the grant is kept and `sa_issue_ok`=0. After reset with no requests, there is no owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sa_req_n | input | 1 | Symmetric agent bus request, active low |
| pa_req_n | input | 1 | Priority agent request, active low |
| sa_lock | input | 1 | Symmetric agent is inside a locked sequence |
| pa_issue | input | 1 | Priority agent issued a transaction this cycle |
| pa_done | input | 1 | One priority agent transaction completed this cycle |
| sa_grant | output | 1 | Bus owned or parked with the symmetric agent |
| pa_grant | output | 1 | Bus owned or parked with the priority agent |
| sa_issue_ok | output | 1 | Symmetric agent may issue new requests |
| pa_drop_ok | output | 1 | Priority request may be withdrawn |
| pa_pending | output | PEND_W | Outstanding priority agent transactions |

## Verification
The assertions assume that the priority agent never signals a completion while nothing is outstanding. They also assume that it does not issue past the counter's range. The count assertion is written to ignore saturation for that reason. The stimulus keeps to these limits: every completion pulse comes after at least one matching issue pulse, and the pending count never goes above two. Early withdrawal of the priority request is driven on purpose, as the one allowed protocol slip, to show that it is ignored.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE    = 3'd0,
        ARB_SA_OWN  = 3'd1,
        ARB_SA_LOCK = 3'd2,
        ARB_SA_PARK = 3'd3,
        ARB_PA_OWN  = 3'd4,
        ARB_PA_PARK = 3'd5
    } arb_state_e;

endpackage

// File: rtl/bus_arb_pend_cnt.sv
module bus_arb_pend_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_ONE;
        end else if (dec && !inc && cnt_q != '0) begin
            cnt_d = cnt_q - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_zero = (cnt_q == '0);

    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R5
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q)); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (cnt_q != '0)); // R5

endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
    import bus_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sa_req_n,
    input  logic       pa_req_n,
    input  logic       sa_lock,
    input  logic       pa_issue,
    input  logic       cnt_zero,
    output arb_state_e state_q
);
    arb_state_e state_d;
    logic       sa_want;
    logic       pa_want;
    logic       pa_release;

    assign sa_want    = !sa_req_n;
    assign pa_want    = !pa_req_n;
    assign pa_release = !pa_want && cnt_zero && !pa_issue;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE, ARB_PA_PARK: begin
                if (pa_want) begin
                    state_d = ARB_PA_OWN;
                end else if (sa_want) begin
                    state_d = ARB_SA_OWN;
                end
            end
            ARB_SA_OWN, ARB_SA_PARK: begin
                if (pa_want && sa_lock) begin
                    state_d = ARB_SA_LOCK;
                end else if (pa_want) begin
                    state_d = ARB_PA_OWN;
                end else if (sa_want) begin
                    state_d = ARB_SA_OWN;
                end else begin
                    state_d = ARB_SA_PARK;
                end
            end
            ARB_SA_LOCK: begin
                if (sa_lock) begin
                    state_d = ARB_SA_LOCK;
                end else if (pa_want) begin
                    state_d = ARB_PA_OWN;
                end else if (sa_want) begin
                    state_d = ARB_SA_OWN;
                end else begin
                    state_d = ARB_SA_PARK;
                end
            end
            ARB_PA_OWN: begin
                if (pa_release) begin
                    state_d = sa_want ? ARB_SA_OWN : ARB_PA_PARK;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    AST_PRIO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ARB_SA_OWN || state_q == ARB_SA_PARK) && !pa_req_n && !sa_lock)
        |=> (state_q == ARB_PA_OWN)); // R3
    AST_LOCK_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_SA_LOCK && sa_lock) |=> (state_q == ARB_SA_LOCK)); // R4
    AST_PA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_PA_OWN && !cnt_zero) |=> (state_q == ARB_PA_OWN)); // R7
    AST_SA_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_PA_OWN && pa_req_n && cnt_zero && !pa_issue && !sa_req_n)
        |=> (state_q == ARB_SA_OWN)); // R8

endmodule

// File: rtl/bus_arb_outdec.sv
module bus_arb_outdec
    import bus_arb_pkg::*;
(
    input  arb_state_e state,
    output logic       sa_grant,
    output logic       pa_grant,
    output logic       sa_issue_ok
);
    always_comb begin
        sa_grant    = 1'b0;
        pa_grant    = 1'b0;
        sa_issue_ok = 1'b0;
        unique case (state)
            ARB_IDLE: ;
            ARB_SA_OWN, ARB_SA_LOCK: begin
                sa_grant    = 1'b1;
                sa_issue_ok = 1'b1;
            end
            ARB_SA_PARK: sa_grant = 1'b1;
            ARB_PA_OWN, ARB_PA_PARK: pa_grant = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
    import bus_arb_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sa_req_n,
    input  logic              pa_req_n,
    input  logic              sa_lock,
    input  logic              pa_issue,
    input  logic              pa_done,
    output logic              sa_grant,
    output logic              pa_grant,
    output logic              sa_issue_ok,
    output logic              pa_drop_ok,
    output logic [PEND_W-1:0] pa_pending
);
    arb_state_e state;
    logic       cnt_zero;

    bus_arb_pend_cnt #(.CNT_W(PEND_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (pa_issue),
        .dec      (pa_done),
        .cnt_q    (pa_pending),
        .cnt_zero (cnt_zero)
    );

    bus_arb_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sa_req_n (sa_req_n),
        .pa_req_n (pa_req_n),
        .sa_lock  (sa_lock),
        .pa_issue (pa_issue),
        .cnt_zero (cnt_zero),
        .state_q  (state)
    );

    bus_arb_outdec i_dec (
        .state       (state),
        .sa_grant    (sa_grant),
        .pa_grant    (pa_grant),
        .sa_issue_ok (sa_issue_ok)
    );

    assign pa_drop_ok = cnt_zero;

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !(sa_grant && pa_grant)); // R9
    AST_NO_ISSUE_UNDER_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_grant && !pa_drop_ok) |=> !sa_issue_ok); // R7

endmodule

// File: tb/test_prio_bus_arbiter.sv
module test_prio_bus_arbiter;

    typedef struct {
        logic       sg;
        logic       pg;
        logic       ok;
        logic       drop;
        logic [3:0] cnt;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sa_req_n = 1'b1;
    logic       pa_req_n = 1'b1;
    logic       sa_lock = 1'b0;
    logic       pa_issue = 1'b0;
    logic       pa_done = 1'b0;
    logic       sa_grant, pa_grant, sa_issue_ok, pa_drop_ok;
    logic [3:0] pa_pending;

    int   total = 0;
    int   bad = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #4 clk = ~clk;

    prio_bus_arbiter #(.PEND_W(4)) i_prio_bus_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sa_req_n    (sa_req_n),
        .pa_req_n    (pa_req_n),
        .sa_lock     (sa_lock),
        .pa_issue    (pa_issue),
        .pa_done     (pa_done),
        .sa_grant    (sa_grant),
        .pa_grant    (pa_grant),
        .sa_issue_ok (sa_issue_ok),
        .pa_drop_ok  (pa_drop_ok),
        .pa_pending  (pa_pending)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        check(e.tag, "sa_grant", int'(sa_grant), int'(e.sg));
        check(e.tag, "pa_grant", int'(pa_grant), int'(e.pg));
        check(e.tag, "sa_issue_ok", int'(sa_issue_ok), int'(e.ok));
        check(e.tag, "pa_drop_ok", int'(pa_drop_ok), int'(e.drop));
        check(e.tag, "pa_pending", int'(pa_pending), int'(e.cnt));
    endtask

    // driver: inputs, then expected outputs after the next rising edge
    task automatic step(input logic sr, input logic pr, input logic lk, input logic is,
                        input logic dn, input logic esg, input logic epg, input logic eok,
                        input logic edrop, input logic [3:0] ecnt, input string tag);
        exp_t e;
        @(negedge clk);
        sa_req_n = sr; pa_req_n = pr; sa_lock = lk; pa_issue = is; pa_done = dn;
        e.sg = esg; e.pg = epg; e.ok = eok; e.drop = edrop; e.cnt = ecnt; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                compare(q.pop_front());
            end
        end
    end

    task automatic reset_and_check(input string tag);
        exp_t e;
        @(negedge clk);
        rst_n = 1'b0;
        sa_req_n = 1'b1; pa_req_n = 1'b1; sa_lock = 1'b0; pa_issue = 1'b0; pa_done = 1'b0;
        @(negedge clk);
        e.sg = 1'b0; e.pg = 1'b0; e.ok = 1'b0; e.drop = 1'b1; e.cnt = 4'd0; e.tag = tag;
        compare(e);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        reset_and_check("R1_reset");
        //    sr    pr    lk    is    dn    sg    pg    ok    drop  cnt
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, "R1_R9_idle");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R3_tie");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, "R8_return");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R3_preempt");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, "R5_R6_inc");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2, "R5_inc2");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, "R7_early");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R6_zero");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, "R8_regain");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, "R9_sapark");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0, "R9_sapark2");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, "R2_fromsa");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, "R4_defer");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, "R4_hold");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R4_unlock");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R9_papark");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R9_papark2");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, "R2_frompa");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R3_again");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, "R5_inc3");
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, "R5_both");
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R5_dec");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, "R9_papark3");
        wait (q.size() == 0);
        reset_and_check("R1_midrun");
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, "R1_after");
        wait (q.size() == 0);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule